// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter decides, for each incoming frame, whether the frame is kept, using only its 48-bit destination address. The receive path streams the first six bytes of the frame into the block, one byte per beat in wire order, and marks the first byte with a start flag. A registered verdict follows: an accept bit and a 3-bit code that names the rule that matched.

Software sets up the filter through a plain write port. The port holds four exact-match slots, a 64-entry hash table split into two 32-bit words, and a mode word. Slot 0 is meant for the station's own address, and slots 1 to 3 take extra unicast addresses. A write to a slot's bottom word switches that slot off. The slot comes back into use only when its top word is written. This lets software change an address without the filter ever matching on half of an old address and half of a new one. The mode word also selects the largest frame size that the rest of the receiver should allow, and that size is output as a number.

The byte input is a valid/ready stream. A byte is consumed on every clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` drops for exactly one cycle, the cycle after the sixth byte, while the verdict is being registered. It is high at all other times. Bytes that arrive when no frame has started, and bytes after the sixth, are consumed and then discarded.

Top module: `rx_addr_filter`

## Requirements
- R1: A beat (`rx_valid` and `rx_ready` high at an edge) with `rx_sof` set stores `rx_data` as address byte 0. The next five beats without `rx_sof` store bytes 1 to 5. Beats may be separated by idle cycles. Beats without `rx_sof` that come before any start, or after the sixth byte, change nothing.
- R2: `dec_valid` is a one-cycle pulse in the second cycle after the edge that takes the sixth byte. `rx_ready` is low only in the cycle between those two edges.
- R3: Write select 0..3 sets slot 0..3 bottom word: address bytes 0..3, with byte 0 in bits 7:0. Select 4..7 sets slot 0..3 top word: bytes 4..5 in bits 15:0. When a destination equals an active slot, the code is slot number + 1.
- R4: A write to a slot's bottom word makes that slot inactive. A write to its top word makes it active.
- R5: The all-ones address gives code 6, unless mode bit 1 (no-broadcast) is set. In that case the broadcast address is not looked up in the hash table.
- R6: Hash index bit i (i = 0..5) is the XOR of address bits i, i+6, ..., i+42, where address bit 0 is bit 0 of byte 0. Select 8 writes hash entries 0..31 and select 9 writes entries 32..63, with entry n at bit (n mod 32). A set entry means a hit.
- R7: With mode bit 2 set, a group address (byte 0 bit 0 = 1) whose hash entry is set gives code 5. With mode bit 2 clear, a group address never hits the hash.
- R8: With mode bit 3 set, an individual address (byte 0 bit 0 = 0) that matches no active slot and whose hash entry is set gives code 5. Mode bit 2 alone does not apply the hash to individual addresses.
- R9: With mode bit 0 (copy-all) set, a frame that no other rule accepts gives code 7.
- R10: Rules apply in priority order: slot (the lowest slot wins), then broadcast, then hash, then copy-all. When none applies, the code is 0. `dec_accept` is 1 exactly when the code is nonzero.
- R11: `frame_limit` is 1536 while mode bit 4 is set and 1518 otherwise. It follows a mode write (select 10) in the next cycle.
- R12: After reset, all slots are inactive, the hash table and the mode word are zero, `rx_ready` is 1 and `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Address byte valid |
| rx_ready | output | 1 | Filter can take a byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_data | input | 8 | Destination address byte |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_code | output | 3 | 0 reject, 1..4 slot, 5 hash, 6 broadcast, 7 copy-all |
| frame_limit | output | 11 | Largest frame size allowed |

## Verification
The decision is tested with several kinds of address. Station and extra-slot unicast addresses, including two slots that hold the same value, show that slot matching works and that the lowest slot wins. The broadcast address is sent with and without the no-broadcast bit. Group and individual addresses are chosen so that their hash index falls in the bottom word in one case and the top word in another, and each is sent with the hash entry set or clear and with the matching enable bit on or off. Taken together, these cases separate the two hash enables from each other and from copy-all. Streams that have stray bytes before a start, idle gaps between beats, or bytes after the sixth show that capture depends only on the start flag and the byte count.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  localparam int NUM_SLOTS = 4;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W = ADDR_BYTES * 8;

  // write select map
  localparam int SEL_SLOT_LO = 0;
  localparam int SEL_SLOT_HI = SEL_SLOT_LO + NUM_SLOTS;
  localparam int SEL_HASH = SEL_SLOT_HI + NUM_SLOTS;
  localparam int SEL_MODE = SEL_HASH + 2;

  typedef enum logic [2:0] {
    MC_REJECT = 3'd0,
    MC_SLOT0  = 3'd1,
    MC_SLOT1  = 3'd2,
    MC_SLOT2  = 3'd3,
    MC_SLOT3  = 3'd4,
    MC_HASH   = 3'd5,
    MC_BCAST  = 3'd6,
    MC_ALL    = 3'd7
  } match_code_e;

  // bit 0 copy_all ... bit 4 big
  typedef struct packed {
    logic big;
    logic uc_hash;
    logic mc_hash;
    logic no_bcast;
    logic copy_all;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs
  import rxaf_pkg::*;
#(
  parameter int SEL_W        = 4,
  parameter int DATA_W       = 32,
  parameter int HASH_ENTRIES = 64
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [SEL_W-1:0]                     cfg_sel,
  input  logic [DATA_W-1:0]                    cfg_wdata,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]     slot_addr,
  output logic [NUM_SLOTS-1:0]                 slot_on,
  output logic [HASH_ENTRIES-1:0]              hash_tbl,
  output mode_t                                mode
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam int HASH_WORDS = HASH_ENTRIES / DATA_W;

  genvar s, w;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [DATA_W-1:0] lo_q;
      logic [HI_W-1:0]   hi_q;
      logic              on_q;
      logic              lo_wr;
      logic              hi_wr;

      assign lo_wr = cfg_we && (cfg_sel == SEL_W'(SEL_SLOT_LO + s));
      assign hi_wr = cfg_we && (cfg_sel == SEL_W'(SEL_SLOT_HI + s));

      // bottom write disarms, top write arms
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
          hi_q <= '0;
          on_q <= 1'b0;
        end else if (lo_wr) begin
          lo_q <= cfg_wdata;
          on_q <= 1'b0;
        end else if (hi_wr) begin
          hi_q <= cfg_wdata[HI_W-1:0];
          on_q <= 1'b1;
        end
      end

      assign slot_addr[s] = {hi_q, lo_q};
      assign slot_on[s]   = on_q;
    end

    for (w = 0; w < HASH_WORDS; w++) begin : g_hword
      logic [DATA_W-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (cfg_we && (cfg_sel == SEL_W'(SEL_HASH + w))) begin
          word_q <= cfg_wdata;
        end
      end

      assign hash_tbl[w*DATA_W +: DATA_W] = word_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (cfg_we && (cfg_sel == SEL_W'(SEL_MODE))) begin
      mode <= mode_t'(cfg_wdata[MODE_W-1:0]);
    end
  end

endmodule

// File: rtl/rxaf_collect.sv
module rxaf_collect
  import rxaf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              eval
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt;
  logic             beat;

  assign rx_ready = !eval;
  assign beat     = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      addr <= '0;
      eval <= 1'b0;
    end else begin
      eval <= 1'b0;
      if (beat) begin
        if (rx_sof) begin
          addr[7:0] <= rx_data;
          cnt       <= CNT_W'(1);
        end else if (cnt != '0 && cnt <= LAST) begin
          for (int b = 1; b < ADDR_BYTES; b++) begin
            if (cnt == CNT_W'(b)) addr[b*8 +: 8] <= rx_data;
          end
          cnt <= cnt + CNT_W'(1);
          if (cnt == LAST) eval <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash
  import rxaf_pkg::*;
#(
  parameter int HASH_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [HASH_W-1:0] idx
);

  genvar g;
  generate
    for (g = 0; g < HASH_W; g++) begin : g_bit
      always_comb begin
        idx[g] = 1'b0;
        for (int k = g; k < ADDR_W; k += HASH_W) idx[g] = idx[g] ^ addr[k];
      end
    end
  endgenerate

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
  import rxaf_pkg::*;
#(
  parameter int HASH_W = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             eval,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr,
  input  logic [NUM_SLOTS-1:0]             slot_on,
  input  logic [(2**HASH_W)-1:0]           hash_tbl,
  input  mode_t                            mode,
  input  logic [HASH_W-1:0]                hash_idx,
  output logic                             dec_valid,
  output logic                             dec_accept,
  output match_code_e                      dec_code
);

  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 is_bcast;
  logic                 is_group;
  logic                 hash_ok;
  match_code_e          code_d;

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_cmp
      assign slot_hit[s] = slot_on[s] && (slot_addr[s] == addr);
    end
  endgenerate

  assign is_bcast = &addr;
  assign is_group = addr[0];
  assign hash_ok  = hash_tbl[hash_idx] && !is_bcast &&
                    (is_group ? mode.mc_hash : mode.uc_hash);

  always_comb begin
    code_d = MC_REJECT;
    if (mode.copy_all) code_d = MC_ALL;
    if (hash_ok) code_d = MC_HASH;
    if (is_bcast && !mode.no_bcast) code_d = MC_BCAST;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slot_hit[i]) code_d = match_code_e'(3'(i + 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_code   <= MC_REJECT;
    end else begin
      dec_valid <= eval;
      if (eval) begin
        dec_code   <= code_d;
        dec_accept <= (code_d != MC_REJECT);
      end
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int CFG_SEL_W  = 4,
  parameter int CFG_DATA_W = 32,
  parameter int HASH_W     = 6,
  parameter int STD_FRAME  = 1518,
  parameter int BIG_FRAME  = 1536,
  parameter int LIMIT_W    = $clog2(BIG_FRAME + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_SEL_W-1:0]  cfg_sel,
  input  logic [CFG_DATA_W-1:0] cfg_wdata,
  input  logic                  rx_valid,
  output logic                  rx_ready,
  input  logic                  rx_sof,
  input  logic [7:0]            rx_data,
  output logic                  dec_valid,
  output logic                  dec_accept,
  output logic [2:0]            dec_code,
  output logic [LIMIT_W-1:0]    frame_limit
);

  localparam int HASH_ENTRIES = 2 ** HASH_W;

  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0]             slot_on;
  logic [HASH_ENTRIES-1:0]          hash_tbl;
  mode_t                            mode;
  logic [ADDR_W-1:0]                addr;
  logic                             eval;
  logic [HASH_W-1:0]                hash_idx;
  match_code_e                      code_q;

  rxaf_regs #(
    .SEL_W       (CFG_SEL_W),
    .DATA_W      (CFG_DATA_W),
    .HASH_ENTRIES(HASH_ENTRIES)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .slot_addr(slot_addr),
    .slot_on  (slot_on),
    .hash_tbl (hash_tbl),
    .mode     (mode)
  );

  rxaf_collect u_collect (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .rx_sof  (rx_sof),
    .rx_data (rx_data),
    .rx_ready(rx_ready),
    .addr    (addr),
    .eval    (eval)
  );

  rxaf_hash #(.HASH_W(HASH_W)) u_hash (
    .addr(addr),
    .idx (hash_idx)
  );

  rxaf_decide #(.HASH_W(HASH_W)) u_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval      (eval),
    .addr      (addr),
    .slot_addr (slot_addr),
    .slot_on   (slot_on),
    .hash_tbl  (hash_tbl),
    .mode      (mode),
    .hash_idx  (hash_idx),
    .dec_valid (dec_valid),
    .dec_accept(dec_accept),
    .dec_code  (code_q)
  );

  assign dec_code    = code_q;
  assign frame_limit = mode.big ? LIMIT_W'(BIG_FRAME) : LIMIT_W'(STD_FRAME);

endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker
  import rxaf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [3:0]  cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic        rx_sof,
  input logic [7:0]  rx_data,
  input logic        dec_valid,
  input logic        dec_accept,
  input logic [2:0]  dec_code,
  input logic [10:0] frame_limit
);

  logic [2:0]        ck_cnt;
  logic [ADDR_W-1:0] ck_addr;
  logic [MODE_W-1:0] ck_mode;
  logic              ck_eval;
  logic [ADDR_W-1:0] ck_dec_addr;
  logic [MODE_W-1:0] ck_dec_mode;
  logic              beat;
  logic              beat_last;

  assign beat      = rx_valid && rx_ready;
  assign beat_last = beat && !rx_sof && ck_cnt == 3'(ADDR_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cnt      <= '0;
      ck_addr     <= '0;
      ck_mode     <= '0;
      ck_eval     <= 1'b0;
      ck_dec_addr <= '0;
      ck_dec_mode <= '0;
    end else begin
      ck_eval <= beat_last;
      if (cfg_we && cfg_sel == 4'(SEL_MODE)) ck_mode <= cfg_wdata[MODE_W-1:0];
      if (beat) begin
        if (rx_sof) begin
          ck_cnt        <= 3'd1;
          ck_addr[7:0]  <= rx_data;
        end else if (ck_cnt != 3'd0 && ck_cnt < 3'(ADDR_BYTES)) begin
          ck_addr[ck_cnt*8 +: 8] <= rx_data;
          ck_cnt                 <= ck_cnt + 3'd1;
        end
      end
      if (ck_eval) begin
        ck_dec_addr <= ck_addr;
        ck_dec_mode <= ck_mode;
      end
    end
  end

  AST_DECIDE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> (!rx_ready && !dec_valid) ##1 dec_valid); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R2
  AST_BCAST_ONLY_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_code == 3'd6) |-> (&ck_dec_addr && !ck_dec_mode[1])); // R5
  AST_GROUP_HASH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_code == 3'd5 && ck_dec_addr[0]) |-> ck_dec_mode[2]); // R7
  AST_INDIV_HASH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_code == 3'd5 && !ck_dec_addr[0]) |-> ck_dec_mode[3]); // R8
  AST_COPY_ALL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_code == 3'd7) |-> ck_dec_mode[0]); // R9
  AST_LIMIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 4'(SEL_MODE)) |=>
      frame_limit == ($past(cfg_wdata[4]) ? 11'd1536 : 11'd1518)); // R11

endmodule

bind rx_addr_filter rxaf_checker u_rxaf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_sof     (rx_sof),
  .rx_data    (rx_data),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .dec_code   (dec_code),
  .frame_limit(frame_limit)
);

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        dec_valid;
  logic        dec_accept;
  logic [2:0]  dec_code;
  logic [10:0] frame_limit;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_sof(rx_sof), .rx_data(rx_data), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_code(dec_code), .frame_limit(frame_limit)
  );

  // mode bits
  localparam logic [31:0] M_ALL = 32'h01, M_NOBC = 32'h02, M_MC = 32'h04,
                          M_UC = 32'h08, M_BIG = 32'h10;

  localparam logic [47:0] A_STA  = 48'h5544_3322_1102;
  localparam logic [47:0] A_X3   = 48'h0a0b_0c0d_0e10;
  localparam logic [47:0] A_DUP  = 48'h6677_8899_aa20;
  localparam logic [47:0] A_Y    = 48'h1357_9bdf_0240;
  localparam logic [47:0] A_BC   = 48'hffff_ffff_ffff;
  localparam logic [47:0] A_G1   = 48'h0000_0000_0001;
  localparam logic [47:0] A_G2   = 48'h0000_0000_0021;
  localparam logic [47:0] A_U    = 48'h0000_0000_0004;
  localparam logic [47:0] A_RND  = 48'h3c5a_7e91_b2c4;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int b = 0; b < 48; b++) h[b % 6] = h[b % 6] ^ a[b];
    return h;
  endfunction

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_slot(input int s, input logic [47:0] a);
    wr(s, a[31:0]);
    wr(4 + s, {16'h0, a[47:32]});
  endtask

  task automatic set_hash_bit(input logic [5:0] idx);
    wr(8, idx < 6'd32 ? (32'h1 << idx[4:0]) : 32'h0);
    wr(9, idx >= 6'd32 ? (32'h1 << idx[4:0]) : 32'h0);
  endtask

  // sends a destination, checks timing, returns code
  task automatic send(input logic [47:0] a, input bit gaps, input string req,
                      output logic [2:0] code, output logic acc);
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      if (gaps && (b == 2 || b == 4)) begin
        rx_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
      end
      rx_valid = 1'b1; rx_sof = (b == 0); rx_data = a[b*8 +: 8];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    check("R2", "ready in decide cycle", 32'(rx_ready), 32'd0);
    check("R2", "valid early", 32'(dec_valid), 32'd0);
    @(negedge clk);
    check("R2", "verdict valid", 32'(dec_valid), 32'd1);
    code = dec_code;
    acc  = dec_accept;
    check("R10", {req, " accept vs code"}, 32'(acc), 32'(code != 3'd0));
    @(negedge clk);
    check("R2", "verdict pulse ends", 32'(dec_valid), 32'd0);
  endtask

  task automatic expect_code(input logic [47:0] a, input string req,
                             input logic [2:0] exp);
    logic [2:0] c; logic ac;
    send(a, 1'b0, req, c, ac);
    check(req, "match code", 32'(c), 32'(exp));
  endtask

  task automatic t_reset;
    check("R12", "ready after reset", 32'(rx_ready), 32'd1);
    check("R12", "no verdict after reset", 32'(dec_valid), 32'd0);
    check("R12", "code after reset", 32'(dec_code), 32'd0);
    check("R11", "default limit", 32'(frame_limit), 32'd1518);
    expect_code(A_STA, "R12", 3'd0);
    wr(10, M_MC);
    expect_code(A_G1, "R12", 3'd0);
    wr(10, 32'h0);
  endtask

  task automatic t_slots;
    set_slot(0, A_STA);
    expect_code(A_STA, "R3", 3'd1);
    set_slot(3, A_X3);
    expect_code(A_X3, "R3", 3'd4);
    set_slot(1, A_DUP);
    set_slot(2, A_DUP);
    expect_code(A_DUP, "R10", 3'd2);
  endtask

  task automatic t_activation;
    set_slot(1, A_Y);
    expect_code(A_Y, "R4", 3'd2);
    wr(1, A_Y[31:0]);
    expect_code(A_Y, "R4", 3'd0);
    wr(5, {16'h0, A_Y[47:32]});
    expect_code(A_Y, "R4", 3'd2);
    expect_code(A_DUP, "R4", 3'd3);
  endtask

  task automatic t_bcast;
    expect_code(A_BC, "R5", 3'd6);
    wr(8, 32'hffff_ffff); wr(9, 32'hffff_ffff);
    wr(10, M_NOBC | M_MC);
    expect_code(A_BC, "R5", 3'd0);
    wr(10, M_NOBC | M_ALL);
    expect_code(A_BC, "R5", 3'd7);
    wr(10, 32'h0);
    wr(8, 32'h0); wr(9, 32'h0);
  endtask

  task automatic t_mc_hash;
    logic [5:0] i1, i2;
    i1 = ref_hash(A_G1);
    i2 = ref_hash(A_G2);
    check("R6", "index of group 1", 32'(i1), 32'd1);
    check("R6", "index of group 2", 32'(i2), 32'd33);
    wr(10, M_MC);
    set_hash_bit(i1);
    expect_code(A_G1, "R6", 3'd5);
    expect_code(A_G2, "R6", 3'd0);
    set_hash_bit(i2);
    expect_code(A_G2, "R6", 3'd5);
    expect_code(A_G1, "R7", 3'd0);
    wr(10, 32'h0);
    expect_code(A_G2, "R7", 3'd0);
  endtask

  task automatic t_uc_hash;
    set_hash_bit(ref_hash(A_U));
    wr(10, M_UC);
    expect_code(A_U, "R8", 3'd5);
    wr(10, M_MC);
    expect_code(A_U, "R8", 3'd0);
    set_hash_bit(ref_hash(A_G1));
    wr(10, M_UC);
    expect_code(A_G1, "R7", 3'd0);
    set_hash_bit(ref_hash(A_STA));
    expect_code(A_STA, "R10", 3'd1);
    wr(10, 32'h0);
    wr(8, 32'h0); wr(9, 32'h0);
  endtask

  task automatic t_copy_all;
    wr(10, M_ALL);
    expect_code(A_RND, "R9", 3'd7);
    expect_code(A_STA, "R10", 3'd1);
    expect_code(A_BC, "R10", 3'd6);
    wr(10, 32'h0);
    expect_code(A_RND, "R9", 3'd0);
  endtask

  task automatic t_capture;
    logic [2:0] c; logic ac;
    // stray bytes with no start
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'hff;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    check("R1", "no verdict from stray bytes", 32'(dec_valid), 32'd0);
    expect_code(A_STA, "R1", 3'd1);
    send(A_X3, 1'b1, "R1", c, ac);
    check("R1", "code with idle gaps", 32'(c), 32'd4);
    // trailing bytes after the sixth
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      check("R1", "no verdict from trailing bytes", 32'(dec_valid), 32'd0);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'h00;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    check("R1", "still no verdict", 32'(dec_valid), 32'd0);
    expect_code(A_Y, "R1", 3'd2);
  endtask

  task automatic t_limit;
    wr(10, M_BIG);
    check("R11", "big limit", 32'(frame_limit), 32'd1536);
    wr(10, 32'h0);
    check("R11", "standard limit", 32'(frame_limit), 32'd1518);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slots();
    t_activation();
    t_bcast();
    t_mc_hash();
    t_uc_hash();
    t_copy_all();
    t_capture();
    t_limit();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule